// File: doc/BRIEF.md
# Single-Wire Slave ROM Selection Layer

This block is the addressing stage of a slave on a single-wire bus. Once a bus reset and presence exchange has taken place, it collects an 8-bit ROM command from the bit layer, least significant bit first. It then either reports the slave's 64-bit identity, compares a 64-bit identity sent by the master, selects the slave outright, or takes part in a bitwise search. The result is a single select flag that hands the bus to the memory layer. A device that is not addressed goes silent until the next bus reset.

The bit layer reports each received bit with a one-cycle strobe. It asks for each transmitted bit with another one-cycle strobe. The block answers a transmit request with a registered pull-down request. Asserting the pull-down sends a 0 and releasing it sends a 1, so several slaves answering at once combine as a wired-AND. The identity is built from a family code input and a serial number input, and the block computes the check byte itself. A second form of the search admits the slave only while an interrupt of its own is still unacknowledged.

Top module: `sw_rom_layer`

## Requirements
- R1: After `rst`, and until the first `bus_reset_i` pulse, `select_o` and `tx_pull_o` are 0 and every bit strobe is ignored.
- R2: After a bus reset, eight received bits, least significant first, form the command. Code 33h makes each following `tx_req_i` send the next identity bit, starting at bit 0 of the family code. `tx_pull_o` is 1 for a 0 bit and 0 for a 1 bit. `select_o` rises with the 64th bit.
- R3: Identity bits 0-7 hold the family code, bits 8-55 hold the serial number and bits 56-63 hold a check byte. The check byte is the CRC with polynomial x^8+x^5+x^4+1, shifted least significant bit first from a zero start over bits 0-55, so that passing all 64 bits through it yields zero.
- R4: Code 55h compares the next 64 received bits with the identity. All 64 equal raises `select_o`. A single difference leaves `select_o` at 0 until the next bus reset, whatever bits follow.
- R5: Code CCh raises `select_o` at the eighth command bit, with no identity transfer.
- R6: Code F0h runs 64 triplets. The first transmit request sends the identity bit, the second sends its complement, and then a received bit is compared with it. A differing bit drops the slave (releases the line, no select) until reset. After 64 equal bits `select_o` rises.
- R7: Code ECh behaves as R6 when `irq_pend_i` is 1 at the eighth command bit. Otherwise the slave drops out until reset.
- R8: Any other command code leaves the slave silent (line released, `select_o` 0) until the next bus reset.
- R9: A `bus_reset_i` pulse in any state clears `select_o`, releases the line and restarts command reception.
- R10: While selected, the block ignores received bits and answers transmit requests by releasing the line.
- R11: A strobe in the wrong direction for the current phase does not advance the transfer: received bits during read or during the send part of a triplet are ignored, and a transmit request while receiving releases the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | One-cycle pulse: bus reset and presence completed |
| rx_vld_i | input | 1 | One-cycle strobe: a bit was received from the master |
| rx_bit_i | input | 1 | Value of the received bit |
| tx_req_i | input | 1 | One-cycle strobe: the bit layer needs the next transmit bit |
| irq_pend_i | input | 1 | Slave has an unacknowledged interrupt |
| family_i | input | 8 | Family code part of the identity |
| serial_i | input | 48 | Serial number part of the identity |
| tx_pull_o | output | 1 | 1 = pull the line low for the current transmit slot |
| select_o | output | 1 | Slave addressed; memory layer may proceed |

## Verification
Every result is registered once. `tx_pull_o` and `select_o` change on the clock edge that accepts a strobe and are valid from the following cycle. The bench therefore drives each strobe for one cycle starting at a falling edge and reads the outputs at the next falling edge, one edge after acceptance. A dropped or selected state is checked at the ports by probing with further transmit requests and received bits, which must leave the outputs unchanged.

// File: rtl/sw_rom_pkg.sv
package sw_rom_pkg;

    localparam int FAM_W = 8;
    localparam int SER_W = 48;
    localparam int CRC_W = 8;
    localparam int CMD_W = 8;
    localparam int DATA_W = FAM_W + SER_W;
    localparam int ID_W = DATA_W + CRC_W;
    localparam int IDX_W = $clog2(ID_W);

    // x^8 + x^5 + x^4 + 1, bit-reversed for LSB-first shifting
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

    localparam logic [CMD_W-1:0] CMD_READ  = 8'h33;
    localparam logic [CMD_W-1:0] CMD_MATCH = 8'h55;
    localparam logic [CMD_W-1:0] CMD_SKIP  = 8'hCC;
    localparam logic [CMD_W-1:0] CMD_SRCH  = 8'hF0;
    localparam logic [CMD_W-1:0] CMD_ISRCH = 8'hEC;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH,
        ST_SEL
    } rom_state_e;

    typedef enum logic [1:0] {
        PH_TRUE,
        PH_COMP,
        PH_DIR
    } srch_phase_e;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_POLY_REFL : '0);
    endfunction

endpackage

// File: rtl/sw_rom_ident.sv
module sw_rom_ident
    import sw_rom_pkg::*;
(
    input  logic [FAM_W-1:0] family_i,
    input  logic [SER_W-1:0] serial_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             id_bit_o
);
    logic [DATA_W-1:0] data_w;
    logic [CRC_W-1:0]  crc_w;
    logic [ID_W-1:0]   id_w;
    logic [CRC_W-1:0]  resid_w;

    assign data_w = {serial_i, family_i};

    always_comb begin
        crc_w = '0;
        for (int i = 0; i < DATA_W; i++) begin
            crc_w = crc_step(crc_w, data_w[i]);
        end
    end

    assign id_w     = {crc_w, data_w};
    assign id_bit_o = id_w[idx_i];

    // residue over the whole identity, used only by the check below
    always_comb begin
        resid_w = '0;
        for (int i = 0; i < ID_W; i++) begin
            resid_w = crc_step(resid_w, id_w[i]);
        end
    end

    always_comb begin
        a_crc_residue_r3: assert (resid_w == '0 || $isunknown(id_w))
            else $error("R3: identity check byte does not close the CRC");
    end

endmodule

// File: rtl/sw_rom_fsm.sv
module sw_rom_fsm
    import sw_rom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset_i,
    input  logic             rx_vld_i,
    input  logic             rx_bit_i,
    input  logic             tx_req_i,
    input  logic             irq_pend_i,
    input  logic             id_bit_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             tx_pull_o,
    output logic             select_o
);
    localparam logic [IDX_W-1:0] LAST_ID  = IDX_W'(ID_W - 1);
    localparam logic [IDX_W-1:0] LAST_CMD = IDX_W'(CMD_W - 1);

    rom_state_e       state_q;
    srch_phase_e      phase_q;
    logic [IDX_W-1:0] cnt_q;
    logic [CMD_W-1:0] cmd_q;
    logic             pull_q;
    logic             sel_q;
    logic [CMD_W-1:0] cmd_full;
    logic             id_last;

    assign cmd_full = {rx_bit_i, cmd_q[CMD_W-1:1]};
    assign id_last  = (cnt_q == LAST_ID);
    assign idx_o    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            phase_q <= PH_TRUE;
            cnt_q   <= '0;
            cmd_q   <= '0;
            pull_q  <= 1'b0;
            sel_q   <= 1'b0;
        end else if (bus_reset_i) begin
            state_q <= ST_CMD;
            phase_q <= PH_TRUE;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
            sel_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_CMD: begin
                    if (tx_req_i) pull_q <= 1'b0;
                    if (rx_vld_i) begin
                        cmd_q <= cmd_full;
                        if (cnt_q == LAST_CMD) begin
                            cnt_q   <= '0;
                            phase_q <= PH_TRUE;
                            case (cmd_full)
                                CMD_READ:  state_q <= ST_READ;
                                CMD_MATCH: state_q <= ST_MATCH;
                                CMD_SKIP: begin
                                    state_q <= ST_SEL;
                                    sel_q   <= 1'b1;
                                end
                                CMD_SRCH:  state_q <= ST_SRCH;
                                CMD_ISRCH: state_q <= irq_pend_i ? ST_SRCH : ST_WAIT;
                                default:   state_q <= ST_WAIT;
                            endcase
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (tx_req_i) begin
                        pull_q <= ~id_bit_i;
                        if (id_last) begin
                            state_q <= ST_SEL;
                            sel_q   <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_MATCH: begin
                    if (tx_req_i) pull_q <= 1'b0;
                    if (rx_vld_i) begin
                        if (rx_bit_i != id_bit_i) begin
                            state_q <= ST_WAIT;
                        end else if (id_last) begin
                            state_q <= ST_SEL;
                            sel_q   <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_SRCH: begin
                    case (phase_q)
                        PH_TRUE: if (tx_req_i) begin
                            pull_q  <= ~id_bit_i;
                            phase_q <= PH_COMP;
                        end
                        PH_COMP: if (tx_req_i) begin
                            pull_q  <= id_bit_i;
                            phase_q <= PH_DIR;
                        end
                        default: begin
                            if (tx_req_i) pull_q <= 1'b0;
                            if (rx_vld_i) begin
                                phase_q <= PH_TRUE;
                                if (rx_bit_i != id_bit_i) begin
                                    state_q <= ST_WAIT;
                                end else if (id_last) begin
                                    state_q <= ST_SEL;
                                    sel_q   <= 1'b1;
                                end else begin
                                    cnt_q <= cnt_q + 1'b1;
                                end
                            end
                        end
                    endcase
                end
                default: begin
                    if (tx_req_i) pull_q <= 1'b0;
                end
            endcase
        end
    end

    assign tx_pull_o = pull_q;
    assign select_o  = sel_q;

    p_reset_clears_sel_r9: assert property (@(posedge clk) disable iff (rst)
        bus_reset_i |=> (!select_o && !tx_pull_o))
        else $error("R9: bus reset did not clear select/pull");

    p_sel_releases_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEL && tx_req_i && !bus_reset_i) |=> !tx_pull_o)
        else $error("R10: line pulled while selected");

    p_sel_held_r10: assert property (@(posedge clk) disable iff (rst)
        (select_o && !bus_reset_i) |=> select_o)
        else $error("R10: select dropped without bus reset");

    p_match_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MATCH && rx_vld_i && !bus_reset_i && rx_bit_i != id_bit_i)
        |=> (state_q == ST_WAIT && !select_o))
        else $error("R4: mismatch did not drop the slave");

    p_comp_inverts_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SRCH && phase_q == PH_COMP && tx_req_i && !bus_reset_i)
        |=> (tx_pull_o != $past(tx_pull_o)))
        else $error("R6: complement slot equals true slot");

    p_sel_source_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(select_o) |-> ($past(state_q) != ST_WAIT && $past(state_q) != ST_SEL))
        else $error("R2: select rose from an idle state");

    p_wait_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && tx_req_i && !bus_reset_i) |=> (!tx_pull_o && !select_o))
        else $error("R8: silent slave drove the line");

endmodule

// File: rtl/sw_rom_layer.sv
module sw_rom_layer
    import sw_rom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset_i,
    input  logic             rx_vld_i,
    input  logic             rx_bit_i,
    input  logic             tx_req_i,
    input  logic             irq_pend_i,
    input  logic [FAM_W-1:0] family_i,
    input  logic [SER_W-1:0] serial_i,
    output logic             tx_pull_o,
    output logic             select_o
);
    logic [IDX_W-1:0] idx_w;
    logic             id_bit_w;

    sw_rom_ident u_ident (
        .family_i (family_i),
        .serial_i (serial_i),
        .idx_i    (idx_w),
        .id_bit_o (id_bit_w)
    );

    sw_rom_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .bus_reset_i (bus_reset_i),
        .rx_vld_i    (rx_vld_i),
        .rx_bit_i    (rx_bit_i),
        .tx_req_i    (tx_req_i),
        .irq_pend_i  (irq_pend_i),
        .id_bit_i    (id_bit_w),
        .idx_o       (idx_w),
        .tx_pull_o   (tx_pull_o),
        .select_o    (select_o)
    );

endmodule

// File: tb/tb_sw_rom_layer.sv
module tb_sw_rom_layer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_reset_i = 1'b0;
    logic        rx_vld_i = 1'b0;
    logic        rx_bit_i = 1'b0;
    logic        tx_req_i = 1'b0;
    logic        irq_pend_i = 1'b0;
    logic [7:0]  family_i = 8'h2A;
    logic [47:0] serial_i = 48'h00A1_5C7E_3B90;
    logic        tx_pull_o;
    logic        select_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sw_rom_layer dut (
        .clk(clk), .rst(rst), .bus_reset_i(bus_reset_i),
        .rx_vld_i(rx_vld_i), .rx_bit_i(rx_bit_i), .tx_req_i(tx_req_i),
        .irq_pend_i(irq_pend_i), .family_i(family_i), .serial_i(serial_i),
        .tx_pull_o(tx_pull_o), .select_o(select_o)
    );

    // {cmd[7:0], irq, expected select, expected pull on first tx request}
    localparam int NV = 8;
    localparam logic [10:0] VEC [NV] = '{
        {8'hCC, 1'b0, 1'b1, 1'b0},   // R5 skip, R10 release
        {8'h33, 1'b0, 1'b0, 1'b1},   // R2 read, family bit0 = 0
        {8'hF0, 1'b0, 1'b0, 1'b1},   // R6 search true slot
        {8'hEC, 1'b1, 1'b0, 1'b1},   // R7 irq pending
        {8'hEC, 1'b0, 1'b0, 1'b0},   // R7 no irq -> drop
        {8'h55, 1'b0, 1'b0, 1'b0},   // R11 tx during match
        {8'h00, 1'b0, 1'b0, 1'b0},   // R8 unknown
        {8'hA5, 1'b0, 1'b0, 1'b0}    // R8 unknown
    };

    logic [63:0] exp_id;

    function automatic logic [7:0] ref_crc(input logic [63:0] v, input int n);
        logic [7:0] r;
        logic f;
        r = 8'h00;
        for (int i = 0; i < n; i++) begin
            f = r[0] ^ v[i];
            r = {f, r[7], r[6], r[5], r[4] ^ f, r[3] ^ f, r[2], r[1]};
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic breset();
        @(negedge clk); bus_reset_i = 1'b1;
        @(negedge clk); bus_reset_i = 1'b0;
    endtask

    task automatic rx(input logic b);
        @(negedge clk); rx_vld_i = 1'b1; rx_bit_i = b;
        @(negedge clk); rx_vld_i = 1'b0;
    endtask

    task automatic tx(output logic p);
        @(negedge clk); tx_req_i = 1'b1;
        @(negedge clk); tx_req_i = 1'b0;
        p = tx_pull_o;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        for (int i = 0; i < 8; i++) rx(c[i]);
    endtask

    // full search pass following own bits, or diverging at bit dv (dv<0: none)
    task automatic search_pass(input string tag, input int dv, output int bad);
        logic p0, p1;
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            tx(p0);
            tx(p1);
            if (dv < 0 || i <= dv) begin
                if (p0 != ~exp_id[i] || p1 != exp_id[i]) bad++;
            end else begin
                if (p0 || p1) bad++;
            end
            rx((i == dv) ? ~exp_id[i] : exp_id[i]);
        end
        check(bad == 0, tag, 64'(bad), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic p;
        logic [63:0] got;
        int bad;

        exp_id = {8'h00, serial_i, family_i};
        exp_id[63:56] = ref_crc(exp_id, 56);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!select_o && !tx_pull_o, "R1 reset state", {tx_pull_o, select_o}, 0);
        send_cmd(8'hCC);
        check(!select_o, "R1 skip before bus reset ignored", select_o, 0);
        tx(p);
        check(!p, "R1 tx before bus reset released", p, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            irq_pend_i = VEC[v][2];
            breset();
            send_cmd(VEC[v][10:3]);
            check(select_o == VEC[v][1], $sformatf("R5/R8 cmd %0h select", VEC[v][10:3]),
                  select_o, VEC[v][1]);
            tx(p);
            check(p == VEC[v][0], $sformatf("R2/R6/R7 cmd %0h first pull", VEC[v][10:3]),
                  p, VEC[v][0]);
        end
        irq_pend_i = 1'b0;

        // R2/R3 full read, with a wrong-direction strobe first (R11)
        breset();
        send_cmd(8'h33);
        rx(1'b1);
        got = '0;
        for (int i = 0; i < 64; i++) begin
            tx(p);
            got[i] = ~p;
            if (i == 62) check(!select_o, "R2 no select before last bit", select_o, 0);
        end
        check(got == exp_id, "R2/R11 identity read", got, exp_id);
        check(got[63:56] == ref_crc(got, 56), "R3 check byte", got[63:56], ref_crc(got, 56));
        check(ref_crc(got, 64) == 8'h00, "R3 residue zero", ref_crc(got, 64), 0);
        check(select_o, "R2 select after read", select_o, 1);
        rx(1'b0);
        tx(p);
        check(select_o && !p, "R10 selected ignores strobes", {p, select_o}, 1);

        // R9 bus reset while selected and mid-read
        breset();
        check(!select_o, "R9 select cleared", select_o, 0);
        send_cmd(8'h33);
        for (int i = 0; i < 5; i++) tx(p);
        breset();
        send_cmd(8'hCC);
        check(select_o, "R9 restart to skip", select_o, 1);

        // R4 match, correct
        breset();
        send_cmd(8'h55);
        for (int i = 0; i < 64; i++) rx(exp_id[i]);
        check(select_o, "R4 match all bits", select_o, 1);

        // R4 match, mismatch at bit 40
        breset();
        send_cmd(8'h55);
        for (int i = 0; i < 64; i++) rx((i == 40) ? ~exp_id[i] : exp_id[i]);
        check(!select_o, "R4 mismatch no select", select_o, 0);
        for (int i = 0; i < 64; i++) rx(exp_id[i]);
        check(!select_o, "R4 stays dropped", select_o, 0);

        // R6 search
        breset();
        send_cmd(8'hF0);
        rx(1'b1);   // R11 ignored in true slot
        search_pass("R6/R11 search triplets", -1, bad);
        check(select_o, "R6 search select", select_o, 1);

        breset();
        send_cmd(8'hF0);
        search_pass("R6 divergence drop", 10, bad);
        check(!select_o, "R6 dropped no select", select_o, 0);

        // R7 interrupt search
        irq_pend_i = 1'b1;
        breset();
        send_cmd(8'hEC);
        search_pass("R7 interrupt search triplets", -1, bad);
        check(select_o, "R7 interrupt search select", select_o, 1);
        irq_pend_i = 1'b0;

        // R8 unknown then later reset recovers
        breset();
        send_cmd(8'h3C);
        for (int i = 0; i < 64; i++) rx(exp_id[i]);
        check(!select_o, "R8 unknown stays silent", select_o, 0);

        finish_run();
    end

endmodule